// File: doc/BRIEF.md
# Descriptor Chain DMA Sequencer

This block is the control sequencer of a single DMA channel. It walks a chain of four-word descriptors and hands each source descriptor, together with the current destination descriptor, to an external data mover. It then waits for the mover to report completion. The descriptors come from one of two places. In register mode they are taken from two 128-bit input buses. In memory mode they are fetched through a small request/response read port: one accepted request returns four 32-bit beats, lowest word first.

When a descriptor completes, the sequencer reads its command field. It can stop, pause, or move to the next descriptor. The next descriptor is either the one that follows in memory (linear chaining) or the one named by a 64-bit pointer stored just after the current descriptor (linked chaining). A paused channel can be resumed in two ways: past the halted descriptor, or from the start addresses again. A descriptor pointer that is not 16-byte aligned latches an error, which the 2-bit state output reports as 3.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, the state output is 0 (disabled), both current pointers are zero, and no read request, mover start or event is active.
- R2: With ctl_ptr_mem=0 (register mode), the source and destination descriptors are taken from reg_src_dscr and reg_dst_dscr. Exactly one descriptor is moved, and the channel then returns to disabled whatever its command field holds.
- R3: A control write with ctl_en=1 while disabled copies src_start and dst_start into src_ptr and dst_ptr. In memory mode it then reads the destination descriptor and the source descriptor, each as four beats with word0 first, before raising mv_start for one cycle. A read request stays up, with a stable address, until it is accepted.
- R4: Descriptor word3 holds cmd in bits 4:3, intr in bit 2 and type in bit 1; the descriptor occupies bits 127:96 with word3, down to word0 in bits 31:0. One cycle after mv_done, ev_done pulses. ev_src_done pulses in the same cycle when intr=1.
- R5: cmd=2 ends the chain with the channel disabled. cmd=0 and cmd=3 advance to the next descriptor.
- R6: For type=0 (linear), the next source pointer is the current pointer plus 16.
- R7: For type=1 (linked), the next source pointer is the 64-bit value read at the current pointer plus 16, low word first, truncated to the address width.
- R8: cmd=1 moves the channel to paused (state 2) and pulses ev_pause in the same cycle as ev_done.
- R9: While paused, a write with ctl_en=1 and ctl_cont=1 resumes the channel. With ctl_cont_addr=0 it advances past the halted descriptor, using that descriptor's type. With ctl_cont_addr=1 it reloads the pointers from the start addresses and fetches the destination descriptor again.
- R10: While paused, a write with ctl_en=0 and ctl_cont=1 disables the channel. A write with ctl_en=1 and ctl_cont=0 leaves it paused.
- R11: A source or destination descriptor pointer whose low four bits are not zero raises ev_src_rd_err or ev_dst_rd_err and stops the channel, and the state output reads 3 until the next write with ctl_en=1 clears the error.
- R12: Control writes that arrive while the channel is enabled (state 1) are ignored, including any change to ctl_ptr_mem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable value of the write |
| ctl_cont | input | 1 | Continue value of the write |
| ctl_cont_addr | input | 1 | Resume from start (1) or from next (0) |
| ctl_ptr_mem | input | 1 | Descriptor source: 0 registers, 1 memory |
| src_start | input | AW | Source chain start address |
| dst_start | input | AW | Destination descriptor start address |
| reg_src_dscr | input | 128 | Source descriptor in register mode |
| reg_dst_dscr | input | 128 | Destination descriptor in register mode |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address, 16-byte aligned |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_data | input | 32 | Response beat data |
| mv_start | output | 1 | One-cycle start to the data mover |
| mv_src_dscr | output | 128 | Source descriptor for the mover |
| mv_dst_dscr | output | 128 | Destination descriptor for the mover |
| mv_done | input | 1 | Mover completion pulse |
| src_ptr | output | AW | Current source descriptor pointer |
| dst_ptr | output | AW | Current destination descriptor pointer |
| state_o | output | 2 | 0 disabled, 1 enabled, 2 paused, 3 error |
| ev_done | output | 1 | Descriptor finished |
| ev_src_done | output | 1 | Finished descriptor had intr set |
| ev_pause | output | 1 | Channel paused on a halt command |
| ev_src_rd_err | output | 1 | Misaligned source descriptor pointer |
| ev_dst_rd_err | output | 1 | Misaligned destination descriptor pointer |

## Verification
When a halting descriptor with intr set completes, the completion, source-done and pause events all fall in one cycle. The bench builds such a descriptor in memory and counts the cycles in which all three pulses are high together. The state must also read paused in that same cycle. Separately, a control write is made to land while a fetch or move is in progress, so that it competes with the running sequence. It is judged by the chain still completing every descriptor.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW = 49,
  parameter int WW = 32,
  parameter int NW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic            ctl_en,
  input  logic            ctl_cont,
  input  logic            ctl_cont_addr,
  input  logic            ctl_ptr_mem,
  input  logic [AW-1:0]   src_start,
  input  logic [AW-1:0]   dst_start,
  input  logic [WW*NW-1:0] reg_src_dscr,
  input  logic [WW*NW-1:0] reg_dst_dscr,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [AW-1:0]   rd_req_addr,
  input  logic            rd_rsp_valid,
  input  logic [WW-1:0]   rd_rsp_data,
  output logic            mv_start,
  output logic [WW*NW-1:0] mv_src_dscr,
  output logic [WW*NW-1:0] mv_dst_dscr,
  input  logic            mv_done,
  output logic [AW-1:0]   src_ptr,
  output logic [AW-1:0]   dst_ptr,
  output logic [1:0]      state_o,
  output logic            ev_done,
  output logic            ev_src_done,
  output logic            ev_pause,
  output logic            ev_src_rd_err,
  output logic            ev_dst_rd_err
);
  localparam int DW   = WW * NW;
  localparam int BW   = $clog2(NW);
  localparam int STEP = DW / 8;
  localparam int LSB  = $clog2(STEP);
  localparam int W3   = 3 * WW;
  localparam logic [AW-1:0] STEP_A = AW'(STEP);
  localparam logic [BW-1:0] LAST_BEAT = BW'(NW - 1);

  typedef enum logic [2:0] {S_OFF, S_PAUSE, S_LDD, S_LDS, S_RREQ, S_RRSP, S_MOVE, S_WAIT} st_t;
  typedef enum logic [1:0] {K_DST, K_SRC, K_NXT} kind_t;

  st_t   st;
  kind_t kind;
  logic  ptr_mem, err;
  logic [AW-1:0] rd_addr;
  logic [BW-1:0] beat;
  logic [NW-2:0][WW-1:0] rbuf;
  logic [DW-1:0] src_q, dst_q;

  wire [DW-1:0]   rsp_full = {rd_rsp_data, rbuf};
  wire [2*WW-1:0] nxt64    = {rbuf[1], rbuf[0]};
  wire [1:0]      s_cmd    = src_q[W3+3 +: 2];
  wire            s_intr   = src_q[W3+2];
  wire            s_linked = src_q[W3+1];

  assign rd_req_valid = (st == S_RREQ);
  assign rd_req_addr  = rd_addr;
  assign mv_start     = (st == S_MOVE);
  assign mv_src_dscr  = src_q;
  assign mv_dst_dscr  = dst_q;

  always_comb begin
    if (err)                 state_o = 2'd3;
    else if (st == S_OFF)    state_o = 2'd0;
    else if (st == S_PAUSE)  state_o = 2'd2;
    else                     state_o = 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF;
      kind <= K_DST;
      ptr_mem <= 1'b0;
      err <= 1'b0;
      rd_addr <= '0;
      beat <= '0;
      rbuf <= '0;
      src_q <= '0;
      dst_q <= '0;
      src_ptr <= '0;
      dst_ptr <= '0;
      {ev_done, ev_src_done, ev_pause, ev_src_rd_err, ev_dst_rd_err} <= '0;
    end else begin
      {ev_done, ev_src_done, ev_pause, ev_src_rd_err, ev_dst_rd_err} <= '0;
      case (st)
        S_OFF, S_PAUSE: if (ctl_wr) begin
          ptr_mem <= ctl_ptr_mem;
          if (ctl_en) err <= 1'b0;
          if (ctl_en && (st == S_OFF || (ctl_cont && ctl_cont_addr))) begin
            src_ptr <= src_start;
            dst_ptr <= dst_start;
            st <= S_LDD;
          end else if (ctl_en && ctl_cont) begin
            if (s_linked) begin
              rd_addr <= src_ptr + STEP_A;
              kind <= K_NXT;
              st <= S_RREQ;
            end else begin
              src_ptr <= src_ptr + STEP_A;
              st <= S_LDS;
            end
          end else if (!ctl_en && ctl_cont && st == S_PAUSE) begin
            st <= S_OFF;
          end
        end
        S_LDD: begin
          if (!ptr_mem) begin
            dst_q <= reg_dst_dscr;
            st <= S_LDS;
          end else if (|dst_ptr[LSB-1:0]) begin
            err <= 1'b1;
            ev_dst_rd_err <= 1'b1;
            st <= S_OFF;
          end else begin
            rd_addr <= dst_ptr;
            kind <= K_DST;
            st <= S_RREQ;
          end
        end
        S_LDS: begin
          if (!ptr_mem) begin
            src_q <= reg_src_dscr;
            st <= S_MOVE;
          end else if (|src_ptr[LSB-1:0]) begin
            err <= 1'b1;
            ev_src_rd_err <= 1'b1;
            st <= S_OFF;
          end else begin
            rd_addr <= src_ptr;
            kind <= K_SRC;
            st <= S_RREQ;
          end
        end
        S_RREQ: if (rd_req_ready) begin
          beat <= '0;
          st <= S_RRSP;
        end
        S_RRSP: if (rd_rsp_valid) begin
          if (beat == LAST_BEAT) begin
            case (kind)
              K_DST: begin dst_q <= rsp_full; st <= S_LDS; end
              K_SRC: begin src_q <= rsp_full; st <= S_MOVE; end
              default: begin src_ptr <= nxt64[AW-1:0]; st <= S_LDS; end
            endcase
          end else begin
            rbuf[beat] <= rd_rsp_data;
            beat <= beat + 1'b1;
          end
        end
        S_MOVE: st <= S_WAIT;
        S_WAIT: if (mv_done) begin
          ev_done <= 1'b1;
          ev_src_done <= s_intr;
          if (!ptr_mem || s_cmd == 2'd2) begin
            st <= S_OFF;
          end else if (s_cmd == 2'd1) begin
            st <= S_PAUSE;
            ev_pause <= 1'b1;
          end else if (s_linked) begin
            rd_addr <= src_ptr + STEP_A;
            kind <= K_NXT;
            st <= S_RREQ;
          end else begin
            src_ptr <= src_ptr + STEP_A;
            st <= S_LDS;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  p_src_done_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_src_done |-> ev_done);

  p_pause_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pause |-> ev_done && state_o == 2'd2);

  p_req_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[LSB-1:0] == '0);

  p_err_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_src_rd_err || ev_dst_rd_err) |-> state_o == 2'd3 && !ev_done);
endmodule

// File: tb/dma_chain_seq_bench.sv
`timescale 1ns/1ps
module dma_chain_seq_bench;
  localparam int AW = 49;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_en = 0, ctl_cont = 0, ctl_cont_addr = 0, ctl_ptr_mem = 0;
  logic [AW-1:0] src_start = '0, dst_start = '0;
  logic [127:0] reg_src_dscr = '0, reg_dst_dscr = '0;
  logic rd_req_valid, rd_req_ready = 0;
  logic [AW-1:0] rd_req_addr;
  logic rd_rsp_valid = 0;
  logic [31:0] rd_rsp_data = '0;
  logic mv_start, mv_done = 0;
  logic [127:0] mv_src_dscr, mv_dst_dscr;
  logic [AW-1:0] src_ptr, dst_ptr;
  logic [1:0] state_o;
  logic ev_done, ev_src_done, ev_pause, ev_src_rd_err, ev_dst_rd_err;

  dma_chain_seq #(.AW(AW)) u_dma_chain_seq (.*);

  always #2 clk = ~clk;

  logic [31:0] mem [0:255];
  int n_tests = 0, n_fail = 0;
  int n_mv = 0, c_done = 0, c_sdone = 0, c_pause = 0, c_serr = 0, c_derr = 0, c_triple = 0;
  logic [127:0] log_src [0:31];
  logic [127:0] log_dst [0:31];
  bit finished = 0;

  // memory read responder
  bit pend = 0, seen_v = 0;
  int bb = 0;
  logic [7:0] base = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; seen_v = 0; rd_req_ready = 0; rd_rsp_valid = 0;
    end else if (pend) begin
      if (rd_rsp_valid) bb++;
      if (bb == 4) begin pend = 0; rd_rsp_valid = 0; end
      else begin rd_rsp_valid = ($urandom % 3) != 0; rd_rsp_data = mem[8'(base + bb)]; end
    end else if (rd_req_ready && seen_v) begin
      pend = 1; seen_v = 0; bb = 0; rd_req_ready = 0;
      rd_rsp_valid = ($urandom % 3) != 0; rd_rsp_data = mem[base];
    end else begin
      seen_v = rd_req_valid;
      base = rd_req_addr[9:2];
      rd_req_ready = rd_req_valid && ($urandom % 2 == 1);
    end
  end

  // data mover model
  int mcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin mv_done = 0; mcnt = 0; end
    else begin
      if (mv_done) mv_done = 0;
      if (mv_start) begin
        if (n_mv < 32) begin log_src[n_mv] = mv_src_dscr; log_dst[n_mv] = mv_dst_dscr; end
        n_mv++;
        mcnt = 1 + $urandom % 3;
      end else if (mcnt > 0) begin
        mcnt--;
        if (mcnt == 0) mv_done = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_done) c_done++;
      if (ev_src_done) c_sdone++;
      if (ev_pause) c_pause++;
      if (ev_src_rd_err) c_serr++;
      if (ev_dst_rd_err) c_derr++;
      if (ev_done && ev_src_done && ev_pause && state_o == 2'd2) c_triple++;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [31:0] a, input logic [16:0] hi, input logic [29:0] sz,
                                      input logic [1:0] cmd, input logic intr, input logic typ);
    return {27'd0, cmd, intr, typ, 1'b0, 2'b00, sz, 15'd0, hi, a};
  endfunction

  task automatic put(input int addr, input logic [127:0] d);
    for (int i = 0; i < 4; i++) mem[8'((addr >> 2) + i)] = d[32*i +: 32];
  endtask

  task automatic clr();
    @(posedge clk); #1;
    n_mv = 0; c_done = 0; c_sdone = 0; c_pause = 0; c_serr = 0; c_derr = 0; c_triple = 0;
  endtask

  task automatic ctl(input logic en, input logic cont, input logic caddr, input logic pm);
    @(negedge clk);
    ctl_wr = 1; ctl_en = en; ctl_cont = cont; ctl_cont_addr = caddr; ctl_ptr_mem = pm;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic wait_idle();
    int i = 0;
    while (state_o == 2'd1 && i < 4000) begin @(negedge clk); i++; end
    repeat (2) @(negedge clk);
  endtask

  logic [127:0] dd, d0, d1, d2, dx;

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5EED);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 state", state_o, 0);
    chk("R1 src_ptr", src_ptr, 0);
    chk("R1 req/start/events", {rd_req_valid, mv_start, ev_done, ev_pause, ev_src_rd_err}, 0);
    rst_n = 1;

    // R2 register mode: halt cmd still ends in disabled
    clr();
    reg_src_dscr = mk(32'h1111, 17'h1, 30'd64, 2'd1, 1'b1, 1'b0);
    reg_dst_dscr = mk(32'h2222, 17'h0, 30'd64, 2'd0, 1'b0, 1'b0);
    ctl(1, 0, 0, 0); wait_idle();
    chk("R2 moves", n_mv, 1);
    chk("R2 src dscr", log_src[0], reg_src_dscr);
    chk("R2 dst dscr", log_dst[0], reg_dst_dscr);
    chk("R2 state", state_o, 0);
    chk("R2 no pause", c_pause, 0);

    // R3 R4 R5 R6 linear chain
    dd = mk(32'hD000, 17'h3, 30'd999, 2'd0, 1'b1, 1'b0);
    put(32'h300, dd);
    d0 = mk(32'hA0, 17'h0, 30'd10, 2'd0, 1'b1, 1'b0);
    d1 = mk(32'hA1, 17'h0, 30'd11, 2'd3, 1'b0, 1'b0);
    d2 = mk(32'hA2, 17'h0, 30'd12, 2'd2, 1'b1, 1'b0);
    put(32'h100, d0); put(32'h110, d1); put(32'h120, d2);
    clr();
    src_start = 49'h100; dst_start = 49'h300;
    ctl(1, 0, 0, 1); wait_idle();
    chk("R3 moves", n_mv, 3);
    chk("R3 first src", log_src[0], d0);
    chk("R3 dst dscr", log_dst[2], dd);
    chk("R5 cmd3 advances", log_src[1], d1);
    chk("R6 linear third", log_src[2], d2);
    chk("R4 done count", c_done, 3);
    chk("R4 src-done count", c_sdone, 2);
    chk("R5 stop state", state_o, 0);
    chk("R6 final src_ptr", src_ptr, 49'h120);
    chk("R3 dst_ptr", dst_ptr, 49'h300);

    // R7 linked chain
    d0 = mk(32'hB0, 17'h0, 30'd5, 2'd0, 1'b0, 1'b1);
    d1 = mk(32'hB1, 17'h0, 30'd6, 2'd2, 1'b0, 1'b1);
    put(32'h040, d0);
    mem[32'h050 >> 2] = 32'h1C0; mem[32'h054 >> 2] = 32'h0;
    put(32'h1C0, d1);
    clr();
    src_start = 49'h040;
    ctl(1, 0, 0, 1); wait_idle();
    chk("R7 moves", n_mv, 2);
    chk("R7 linked target", log_src[1], d1);
    chk("R7 src_ptr", src_ptr, 49'h1C0);

    // R8 halt, R10 enable without continue, R9 resume next
    d0 = mk(32'hC0, 17'h0, 30'd7, 2'd1, 1'b1, 1'b0);
    d1 = mk(32'hC1, 17'h0, 30'd8, 2'd2, 1'b0, 1'b0);
    put(32'h080, d0); put(32'h090, d1);
    clr();
    src_start = 49'h080;
    ctl(1, 0, 0, 1); wait_idle();
    chk("R8 paused state", state_o, 2);
    chk("R8 pause event", c_pause, 1);
    chk("R8 done+src-done+pause same cycle", c_triple, 1);
    ctl(1, 0, 0, 1); wait_idle();
    chk("R10 enable without continue stays paused", state_o, 2);
    chk("R10 no extra move", n_mv, 1);
    ctl(1, 1, 0, 1); wait_idle();
    chk("R9 resume next moves", n_mv, 2);
    chk("R9 resume next dscr", log_src[1], d1);
    chk("R9 resume next state", state_o, 0);
    chk("R9 resume next src_ptr", src_ptr, 49'h090);

    // R9 resume from start
    d0 = mk(32'hE0, 17'h0, 30'd7, 2'd1, 1'b0, 1'b0);
    d1 = mk(32'hE1, 17'h0, 30'd9, 2'd2, 1'b0, 1'b0);
    dx = mk(32'hF00D, 17'h2, 30'd77, 2'd0, 1'b0, 1'b0);
    put(32'h0A0, d0); put(32'h0C0, d1); put(32'h310, dx);
    clr();
    src_start = 49'h0A0; dst_start = 49'h300;
    ctl(1, 0, 0, 1); wait_idle();
    src_start = 49'h0C0; dst_start = 49'h310;
    ctl(1, 1, 1, 1); wait_idle();
    chk("R9 restart moves", n_mv, 2);
    chk("R9 restart src dscr", log_src[1], d1);
    chk("R9 restart dst reload", log_dst[1], dx);
    chk("R9 restart dst_ptr", dst_ptr, 49'h310);

    // R10 disable from pause
    clr();
    src_start = 49'h0A0; dst_start = 49'h300;
    ctl(1, 0, 0, 1); wait_idle();
    ctl(0, 1, 0, 1); wait_idle();
    chk("R10 disable from pause", state_o, 0);
    chk("R10 disable moves", n_mv, 1);

    // R11 misaligned source start, then recovery
    clr();
    src_start = 49'h104;
    ctl(1, 0, 0, 1); wait_idle();
    chk("R11 src err state", state_o, 3);
    chk("R11 src err event", c_serr, 1);
    chk("R11 src err no move", n_mv, 0);
    src_start = 49'h100;
    ctl(1, 0, 0, 1); wait_idle();
    chk("R11 recovered state", state_o, 0);
    chk("R11 recovered moves", n_mv, 3);
    clr();
    dst_start = 49'h308; src_start = 49'h100;
    ctl(1, 0, 0, 1); wait_idle();
    chk("R11 dst err state", state_o, 3);
    chk("R11 dst err event", c_derr, 1);
    chk("R11 dst err no move", n_mv, 0);
    dst_start = 49'h300;
    // linked pointer to a misaligned address
    mem[32'h050 >> 2] = 32'h1C4;
    clr();
    src_start = 49'h040;
    ctl(1, 0, 0, 1); wait_idle();
    chk("R11 linked misaligned state", state_o, 3);
    chk("R11 linked misaligned moves", n_mv, 1);
    chk("R11 linked misaligned event", c_serr, 1);

    // R12 write during run ignored
    clr();
    src_start = 49'h100;
    ctl(1, 0, 0, 1);
    ctl(0, 1, 1, 0);
    wait_idle();
    chk("R12 run unaffected moves", n_mv, 3);
    chk("R12 run unaffected state", state_o, 0);

    // random linear chains
    for (int it = 0; it < 20; it++) begin
      int len, b, ni;
      logic [127:0] ch [0:4];
      len = 1 + $urandom % 5;
      b = 32'h100 + 16 * ($urandom % 16);
      ni = 0;
      for (int k = 0; k < len; k++) begin
        logic [1:0] cm;
        logic in;
        cm = (k == len - 1) ? 2'd2 : (($urandom % 2) ? 2'd3 : 2'd0);
        in = 1'($urandom % 2);
        if (in) ni++;
        ch[k] = mk($urandom, 17'($urandom), 30'($urandom), cm, in, 1'b0);
        put(b + 16 * k, ch[k]);
      end
      clr();
      src_start = AW'(b);
      ctl(1, 0, 0, 1); wait_idle();
      chk("R3 random moves", n_mv, len);
      for (int k = 0; k < len; k++) chk("R6 random dscr", log_src[k], ch[k]);
      chk("R4 random src-done", c_sdone, ni);
      chk("R6 random src_ptr", src_ptr, AW'(b + 16 * (len - 1)));
      chk("R5 random state", state_o, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule